// File: doc/BRIEF.md
# Eight-Operation Small-Operand ALU

This block is a purely combinational arithmetic and logic unit for two small unsigned operands. A 3-bit operation code picks one of eight functions: sum, difference, product, quotient, remainder, and three comparisons (equal, greater, less). Every function returns its answer on one shared result word that is wider than the operands, so a full product and a wrapped difference both fit without loss.

There is no clock and no state inside the block. The result follows the inputs as soon as the logic settles. A parent design can therefore sample it in the same cycle in which it presents the operands. A separate flag reports a quotient or remainder request with a zero divisor. In that case the result takes a fixed, defined value, so nothing downstream ever sees an undefined answer.

The operand width and the result width are parameters. The defaults are 4-bit operands and a 16-bit result.

Top module: `opnd_alu`

## Requirements
- R1: With `op_code` = 3'b000 the result is the sum of the two operands, zero-extended to the result width (15+15 gives 16'h001E).
- R2: With `op_code` = 3'b001 the result is `opnd_a` minus `opnd_b` in two's complement, taken modulo 2^16 (2−5 gives 16'hFFFD, 0−15 gives 16'hFFF1).
- R3: With `op_code` = 3'b010 the result is the full unsigned product, zero-extended (15×15 gives 16'h00E1).
- R4: With `op_code` = 3'b011 the result is the truncated unsigned quotient. When `opnd_b` is zero the result is 16'hFFFF.
- R5: With `op_code` = 3'b100 the result is the unsigned remainder. When `opnd_b` is zero the result is `opnd_a`, zero-extended.
- R6: `div_zero` is 1 exactly when `op_code` is 3'b011 or 3'b100 and `opnd_b` is zero, and is 0 otherwise.
- R7: With `op_code` 3'b101 (equal), 3'b110 (`opnd_a` greater) or 3'b111 (`opnd_a` less), bit 0 of the result is 1 when the relation holds and 0 when it does not, and bits 15:1 are 0.
- R8: The result and `div_zero` settle to their new values after any input change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 4 | First unsigned operand (left-hand side) |
| opnd_b | input | 4 | Second unsigned operand (right-hand side, divisor) |
| op_code | input | 3 | Function select, encoded as in R1–R7 |
| result | output | 16 | Result word of the selected function |
| div_zero | output | 1 | High when a quotient or remainder is requested with a zero divisor |

## Verification
A table of hand-picked vectors comes first, one block of rows per function:
- zero operands and full-scale operands;
- wrapping differences;
- exact and inexact division;
- equal, greater and lesser pairs for each comparison.

These rows separate a correct wrap or fill value from one that is off by a bit.

An exhaustive sweep over every operand pair under every opcode follows. It is compared against a model written from the requirements, and it shows any cross-talk between the functions sharing the result word.

Directed cases then change the inputs in the middle of a clock phase. These show that the result tracks the inputs without any clock edge. They also show that `div_zero` rises only for the two division codes with a zero divisor.

// File: rtl/opnd_alu_pkg.sv
package opnd_alu_pkg;

    localparam int OPND_W_DEF = 4;
    localparam int RES_W_DEF  = 16;
    localparam int OP_W       = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_MUL = 3'b010,
        OP_DIV = 3'b011,
        OP_MOD = 3'b100,
        OP_EQ  = 3'b101,
        OP_GT  = 3'b110,
        OP_LT  = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        RELN_EQ = 2'd0,
        RELN_GT = 2'd1,
        RELN_LT = 2'd2
    } reln_e;

    typedef struct packed {
        logic  is_sub;
        logic  is_div_class;
        logic  is_cmp;
        reln_e reln;
    } op_dec_t;

    function automatic op_dec_t decode_op(alu_op_e op);
        op_dec_t d;
        d.is_sub       = (op == OP_SUB);
        d.is_div_class = (op == OP_DIV) || (op == OP_MOD);
        d.is_cmp       = (op == OP_EQ) || (op == OP_GT) || (op == OP_LT);
        unique case (op)
            OP_GT:   d.reln = RELN_GT;
            OP_LT:   d.reln = RELN_LT;
            default: d.reln = RELN_EQ;
        endcase
        return d;
    endfunction

    typedef struct packed {
        logic eq;
        logic gt;
        logic lt;
    } cmp_res_t;

endpackage

// File: rtl/opnd_alu_addsub.sv
module opnd_alu_addsub #(
    parameter int OPND_W = 4,
    parameter int RES_W  = 16
) (
    input  logic [OPND_W-1:0] lhs,
    input  logic [OPND_W-1:0] rhs,
    input  logic              do_sub,
    output logic [RES_W-1:0]  sum
);
    logic [RES_W-1:0] lhs_x;
    logic [RES_W-1:0] rhs_x;
    logic [RES_W-1:0] rhs_eff;

    assign lhs_x   = RES_W'(lhs);
    assign rhs_x   = RES_W'(rhs);
    // one adder serves both: subtract adds the inverted operand plus one
    assign rhs_eff = do_sub ? ~rhs_x : rhs_x;
    assign sum     = lhs_x + rhs_eff + RES_W'(do_sub);
endmodule

// File: rtl/opnd_alu_mul.sv
module opnd_alu_mul #(
    parameter int OPND_W = 4
) (
    input  logic [OPND_W-1:0]   mcand,
    input  logic [OPND_W-1:0]   mplier,
    output logic [2*OPND_W-1:0] prod
);
    localparam int PW = 2 * OPND_W;

    logic [PW-1:0] acc [0:OPND_W];

    assign acc[0] = '0;

    generate
        for (genvar i = 0; i < OPND_W; i++) begin : g_row
            logic [PW-1:0] partial;
            assign partial    = mplier[i] ? (PW'(mcand) << i) : '0;
            assign acc[i + 1] = acc[i] + partial;
        end
    endgenerate

    assign prod = acc[OPND_W];
endmodule

// File: rtl/opnd_alu_div.sv
module opnd_alu_div #(
    parameter int OPND_W = 4
) (
    input  logic [OPND_W-1:0] dvd,
    input  logic [OPND_W-1:0] dvs,
    output logic [OPND_W-1:0] quo,
    output logic [OPND_W-1:0] rem,
    output logic              dvs_zero
);
    // restoring array: one compare-subtract row per dividend bit, MSB first
    logic [OPND_W-1:0] part [0:OPND_W];

    assign part[0] = '0;

    generate
        for (genvar i = 0; i < OPND_W; i++) begin : g_stage
            localparam int BIT = OPND_W - 1 - i;
            logic [OPND_W:0] trial;
            logic            fits;
            assign trial       = {part[i], dvd[BIT]};
            assign fits        = trial >= {1'b0, dvs};
            assign quo[BIT]    = fits;
            assign part[i + 1] = fits ? OPND_W'(trial - {1'b0, dvs})
                                      : trial[OPND_W-1:0];
        end
    endgenerate

    assign rem      = part[OPND_W];
    assign dvs_zero = (dvs == '0);
endmodule

// File: rtl/opnd_alu_cmp.sv
module opnd_alu_cmp
    import opnd_alu_pkg::*;
#(
    parameter int OPND_W = 4
) (
    input  logic [OPND_W-1:0] lhs,
    input  logic [OPND_W-1:0] rhs,
    output cmp_res_t          rel
);
    // MSB-first scan: first differing bit decides the ordering
    logic [OPND_W:0] undecided;
    logic [OPND_W:0] gt_seen;
    logic [OPND_W:0] lt_seen;

    assign undecided[OPND_W] = 1'b1;
    assign gt_seen[OPND_W]   = 1'b0;
    assign lt_seen[OPND_W]   = 1'b0;

    generate
        for (genvar i = OPND_W - 1; i >= 0; i--) begin : g_bit
            assign gt_seen[i]   = gt_seen[i + 1] | (undecided[i + 1] & lhs[i] & ~rhs[i]);
            assign lt_seen[i]   = lt_seen[i + 1] | (undecided[i + 1] & ~lhs[i] & rhs[i]);
            assign undecided[i] = undecided[i + 1] & ~(lhs[i] ^ rhs[i]);
        end
    endgenerate

    assign rel.eq = undecided[0];
    assign rel.gt = gt_seen[0];
    assign rel.lt = lt_seen[0];
endmodule

// File: rtl/opnd_alu.sv
module opnd_alu
    import opnd_alu_pkg::*;
#(
    parameter int OPND_W = OPND_W_DEF,
    parameter int RES_W  = RES_W_DEF
) (
    input  logic [OPND_W-1:0] opnd_a,
    input  logic [OPND_W-1:0] opnd_b,
    input  logic [OP_W-1:0]   op_code,
    output logic [RES_W-1:0]  result,
    output logic              div_zero
);
    localparam int PROD_W = 2 * OPND_W;

    alu_op_e           op_e;
    op_dec_t           dec;
    logic [RES_W-1:0]  as_sum;
    logic [PROD_W-1:0] mul_prod;
    logic [OPND_W-1:0] div_q;
    logic [OPND_W-1:0] div_r;
    logic              b_zero;
    cmp_res_t          rel;
    logic              rel_bit;

    assign op_e = alu_op_e'(op_code);
    assign dec  = decode_op(op_e);

    opnd_alu_addsub #(.OPND_W(OPND_W), .RES_W(RES_W)) u_addsub (
        .lhs    (opnd_a),
        .rhs    (opnd_b),
        .do_sub (dec.is_sub),
        .sum    (as_sum)
    );

    opnd_alu_mul #(.OPND_W(OPND_W)) u_mul (
        .mcand  (opnd_a),
        .mplier (opnd_b),
        .prod   (mul_prod)
    );

    opnd_alu_div #(.OPND_W(OPND_W)) u_div (
        .dvd      (opnd_a),
        .dvs      (opnd_b),
        .quo      (div_q),
        .rem      (div_r),
        .dvs_zero (b_zero)
    );

    opnd_alu_cmp #(.OPND_W(OPND_W)) u_cmp (
        .lhs (opnd_a),
        .rhs (opnd_b),
        .rel (rel)
    );

    always_comb begin
        unique case (dec.reln)
            RELN_GT: rel_bit = rel.gt;
            RELN_LT: rel_bit = rel.lt;
            default: rel_bit = rel.eq;
        endcase
    end

    always_comb begin
        unique case (op_e)
            OP_ADD, OP_SUB: result = as_sum;
            OP_MUL:         result = RES_W'(mul_prod);
            OP_DIV:         result = b_zero ? '1 : RES_W'(div_q);
            OP_MOD:         result = b_zero ? RES_W'(opnd_a) : RES_W'(div_r);
            default:        result = RES_W'(rel_bit);
        endcase
    end

    assign div_zero = dec.is_div_class & b_zero;
endmodule

module opnd_alu_chk #(
    parameter int OPND_W = 4,
    parameter int RES_W  = 16
) (
    input logic [OPND_W-1:0] opnd_a,
    input logic [OPND_W-1:0] opnd_b,
    input logic [2:0]        op_code,
    input logic [RES_W-1:0]  result,
    input logic              div_zero
);
    always_comb begin
        if (op_code == 3'b000) begin
            a_r1_sum_bound: assert (result <= RES_W'(2 * ((1 << OPND_W) - 1)) &&
                                    result[0] == (opnd_a[0] ^ opnd_b[0]))
                else $error("R1 sum out of range or wrong parity");
        end
        if (op_code == 3'b001) begin
            a_r2_sub_inverse: assert (RES_W'(result + RES_W'(opnd_b)) == RES_W'(opnd_a))
                else $error("R2 difference plus subtrahend differs from minuend");
        end
        if (op_code == 3'b010) begin
            a_r3_mul_zero: assert (((opnd_a != '0) && (opnd_b != '0)) || result == '0)
                else $error("R3 product with zero factor not zero");
        end
        if (op_code == 3'b011 && opnd_b != '0) begin
            a_r4_quot_range: assert (32'(result) * 32'(opnd_b) <= 32'(opnd_a) &&
                                     (32'(result) + 32'd1) * 32'(opnd_b) > 32'(opnd_a))
                else $error("R4 quotient not the truncated value");
        end
        if (op_code == 3'b011 && opnd_b == '0) begin
            a_r4_quot_zero: assert (result == '1)
                else $error("R4 zero-divisor quotient not all ones");
        end
        if (op_code == 3'b100) begin
            a_r5_rem_range: assert ((opnd_b == '0) ? (result == RES_W'(opnd_a))
                                                   : (result < RES_W'(opnd_b)))
                else $error("R5 remainder out of range");
        end
        a_r6_flag: assert (div_zero == ((op_code == 3'b011 || op_code == 3'b100) &&
                                        opnd_b == '0))
            else $error("R6 zero-divisor flag wrong");
        if (op_code >= 3'b101) begin
            a_r7_cmp_upper: assert (result[RES_W-1:1] == '0)
                else $error("R7 comparison upper bits not zero");
        end
    end
endmodule

bind opnd_alu opnd_alu_chk #(.OPND_W(OPND_W), .RES_W(RES_W)) u_chk (
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .op_code  (op_code),
    .result   (result),
    .div_zero (div_zero)
);

// File: tb/opnd_alu_tb.sv
module opnd_alu_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] a   = '0;
    logic [3:0] b   = '0;
    logic [2:0] op  = '0;
    logic [15:0] res;
    logic        dz;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    opnd_alu u_dut (
        .opnd_a   (a),
        .opnd_b   (b),
        .op_code  (op),
        .result   (res),
        .div_zero (dz)
    );

    // op(3) a(4) b(4) expected(16)
    localparam int NV = 23;
    localparam logic [26:0] VEC [0:NV-1] = '{
        {3'd0, 4'd0,  4'd0,  16'h0000},
        {3'd0, 4'd15, 4'd15, 16'h001E},
        {3'd0, 4'd7,  4'd9,  16'h0010},
        {3'd1, 4'd5,  4'd2,  16'h0003},
        {3'd1, 4'd2,  4'd5,  16'hFFFD},
        {3'd1, 4'd0,  4'd15, 16'hFFF1},
        {3'd1, 4'd9,  4'd9,  16'h0000},
        {3'd2, 4'd15, 4'd15, 16'h00E1},
        {3'd2, 4'd7,  4'd0,  16'h0000},
        {3'd2, 4'd3,  4'd5,  16'h000F},
        {3'd3, 4'd15, 4'd4,  16'h0003},
        {3'd3, 4'd14, 4'd7,  16'h0002},
        {3'd3, 4'd9,  4'd0,  16'hFFFF},
        {3'd3, 4'd0,  4'd3,  16'h0000},
        {3'd4, 4'd15, 4'd4,  16'h0003},
        {3'd4, 4'd9,  4'd0,  16'h0009},
        {3'd4, 4'd13, 4'd13, 16'h0000},
        {3'd5, 4'd6,  4'd6,  16'h0001},
        {3'd5, 4'd6,  4'd7,  16'h0000},
        {3'd6, 4'd8,  4'd7,  16'h0001},
        {3'd6, 4'd5,  4'd5,  16'h0000},
        {3'd7, 4'd3,  4'd12, 16'h0001},
        {3'd7, 4'd12, 4'd3,  16'h0000}
    };

    function automatic string tag_of(logic [2:0] o);
        case (o)
            3'd0:    return "R1";
            3'd1:    return "R2";
            3'd2:    return "R3";
            3'd3:    return "R4";
            3'd4:    return "R5";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [15:0] model(logic [2:0] o, logic [3:0] x, logic [3:0] y);
        int xi = int'(x);
        int yi = int'(y);
        case (o)
            3'd0:    return 16'(xi + yi);
            3'd1:    return 16'(xi - yi);
            3'd2:    return 16'(xi * yi);
            3'd3:    return (yi == 0) ? 16'hFFFF : 16'(xi / yi);
            3'd4:    return (yi == 0) ? 16'(xi)  : 16'(xi % yi);
            3'd5:    return (xi == yi) ? 16'd1 : 16'd0;
            3'd6:    return (xi > yi)  ? 16'd1 : 16'd0;
            default: return (xi < yi)  ? 16'd1 : 16'd0;
        endcase
    endfunction

    function automatic logic model_dz(logic [2:0] o, logic [3:0] y);
        return (o == 3'd3 || o == 3'd4) && (y == 4'd0);
    endfunction

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%0d b=%0d got=%h exp=%h", tag, op, a, b, got, exp);
        end
    endtask

    task automatic apply(logic [2:0] o, logic [3:0] x, logic [3:0] y);
        @(negedge clk);
        op = o; a = x; b = y;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle state: zero inputs give zero sum and no flag (R1, R6)
        apply(3'd0, 4'd0, 4'd0);
        check("R1 idle", res, 16'h0000);
        check("R6 idle", 16'(dz), 16'h0000);

        // vector table
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][26:24], VEC[i][23:20], VEC[i][19:16]);
            check(tag_of(VEC[i][26:24]), res, VEC[i][15:0]);
        end

        // exhaustive sweep against the model
        for (int o = 0; o < 8; o++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    apply(3'(o), 4'(x), 4'(y));
                    check(tag_of(3'(o)), res, model(3'(o), 4'(x), 4'(y)));
                    check("R6", 16'(dz), 16'(model_dz(3'(o), 4'(y))));
                end
            end
        end

        // R6: zero divisor flag only for the two division codes
        apply(3'd2, 4'd9, 4'd0);
        check("R6 mul zero b", 16'(dz), 16'h0000);
        apply(3'd4, 4'd0, 4'd0);
        check("R6 mod 0/0", 16'(dz), 16'h0001);
        check("R5 mod 0/0", res, 16'h0000);

        // R8: inputs change mid high phase, result follows before any edge
        @(posedge clk);
        #0.5;
        op = 3'd1; a = 4'd2; b = 4'd5;
        #0.5;
        check("R8 mid-phase sub", res, 16'hFFFD);
        op = 3'd3; b = 4'd0;
        #0.5;
        check("R8 mid-phase div", res, 16'hFFFF);
        check("R8 mid-phase flag", 16'(dz), 16'h0001);
        op = 3'd7; a = 4'd1; b = 4'd2;
        #0.5;
        check("R8 mid-phase lt", res, 16'h0001);

        finish_run();
    end
endmodule